// File: doc/BRIEF.md
# Firmware Hub Bus Target Engine

This block is the target side of a 4-bit multiplexed firmware-hub bus. A host frames each transfer by pulling an active-low frame input low. It then sends a start code, a device-select nibble, seven address nibbles and a size nibble, one nibble per clock. The engine decodes single-byte memory reads and writes and matches the select nibble against a strap input. It hands the access to a storage back end through a plain request interface. The engine then takes over the nibble lines for the sync, data and turnaround-back clocks, and releases them afterwards.

Towards storage it presents a 20-bit decoded address, a region select (core or register space, taken from address bit 22), a write byte, a one-clock read strobe and a one-clock write strobe. It accepts a read byte back. A busy output shows that the engine is away from idle. The engine drops a cycle that carries a bad start code, a foreign select nibble or a non-zero size. If the host pulls frame low while a cycle is in progress, the engine aborts the cycle and waits for an all-ones nibble before it becomes ready again.

Top module: `fwh_target`

## Requirements
- R1: While `frame_n` is low, each clock's nibble is taken as the start code, and the last one before `frame_n` returns high is the one used. 4'hD means read and 4'hE means write. Any other code leads to no response and no strobe.
- R2: The first nibble with `frame_n` high is the select. If it differs from `id_strap`, the engine returns to idle with no strobe and no drive for the rest of the cycle.
- R3: Seven address nibbles follow the select, most significant first. `st_addr` carries bits 19..0 of that 28-bit address, and `st_core` carries bit 22.
- R4: A size nibble other than 4'h0 ends the cycle with no strobe and no drive.
- R5: Read: `st_rd` is high for exactly the one clock after the size nibble. `rd_data` is taken one clock later. Two clocks after the strobe the engine drives 4'h0, then the low nibble, then the high nibble, then 4'hF, and it stops driving on the next clock.
- R6: Write: the low and then the high data nibble follow the size. `st_wr` is high for exactly the one clock after the high nibble, with `st_wdata` valid. Two clocks after the strobe the engine drives 4'h0, then 4'hF, and then floats.
- R7: `frame_n` low at any clock from the first address nibble to the last driven clock aborts the cycle. Driving stops on the next clock, and `busy` stays high until the host presents 4'hF on `lad_in`.
- R8: `rst_n` low forces `lad_oe` low at once and returns the engine to idle with `busy` low.
- R9: `lad_oe` is high only in the target-owned clocks listed in R5 and R6. While it is low, `lad_out` reads 4'hF.
- R10: `busy` is low in idle and high from the clock after the first frame-low clock until the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame/start marker |
| lad_in | input | 4 | Nibble lines as seen from the pads |
| lad_out | output | 4 | Nibble value to drive |
| lad_oe | output | 1 | Tri-state enable for lad_out |
| id_strap | input | 4 | Device select strap |
| st_addr | output | 20 | Decoded address to storage |
| st_core | output | 1 | 1 = memory core, 0 = register space |
| st_wdata | output | 8 | Write byte to storage |
| st_rdata | input | 8 | Read byte from storage |
| st_rd | output | 1 | One-clock read request |
| st_wr | output | 1 | One-clock write request |
| busy | output | 1 | Engine not idle |

## Verification
Clocks are counted from the first frame-low nibble as clock 0. For a read, the strobe appears in clock 10 and the driven nibbles in clocks 12 to 15. For a write, the strobe appears in clock 12, with sync and 4'hF in clocks 14 and 15. Idle follows in clock 16. The bench drives each nibble just after a rising edge and samples every output in that same clock interval. Each check is therefore tied to a fixed clock index and compared against the expected value for that index. In the abort and reset tests, the bench samples the enable on the clock after the abort nibble and immediately after `rst_n` falls.

// File: rtl/fwh_target.sv
module fwh_target #(
  parameter int NIBBLES  = 7,
  parameter int DEC_W    = 20,
  parameter int CORE_BIT = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [3:0]       lad_in,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  input  logic [3:0]       id_strap,
  output logic [DEC_W-1:0] st_addr,
  output logic             st_core,
  output logic [7:0]       st_wdata,
  input  logic [7:0]       st_rdata,
  output logic             st_rd,
  output logic             st_wr,
  output logic             busy
);
  localparam int FULL_W = 4 * NIBBLES;
  localparam int CNT_W  = $clog2(NIBBLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBBLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_SIZE, S_WLO, S_WHI, S_TARA,
    S_TARB, S_SYNC, S_DLO, S_DHI, S_TBK, S_ABORT
  } st_t;

  st_t              st;
  logic             kind_ok, is_wr;
  logic [CNT_W-1:0] cnt;
  logic [FULL_W-1:0] addr;
  logic [7:0]       wbuf, rbuf;
  logic             in_cycle;

  assign in_cycle = (st >= S_ADDR) && (st <= S_TBK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_ok <= 1'b0;
      is_wr   <= 1'b0;
      cnt     <= '0;
      addr    <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
    end else if (in_cycle && !frame_n) begin
      st <= S_ABORT;
    end else begin
      case (st)
        S_IDLE, S_START: begin
          if (!frame_n) begin
            st      <= S_START;
            kind_ok <= (lad_in == 4'hD) || (lad_in == 4'hE);
            is_wr   <= (lad_in == 4'hE);
          end else if (st == S_START) begin
            cnt <= '0;
            st  <= (kind_ok && lad_in == id_strap) ? S_ADDR : S_IDLE;
          end
        end
        S_ADDR: begin
          addr <= {addr[FULL_W-5:0], lad_in};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) st <= S_SIZE;
        end
        S_SIZE: st <= (lad_in != 4'h0) ? S_IDLE : (is_wr ? S_WLO : S_TARA);
        S_WLO: begin wbuf[3:0] <= lad_in; st <= S_WHI; end
        S_WHI: begin wbuf[7:4] <= lad_in; st <= S_TARA; end
        S_TARA: st <= S_TARB;
        S_TARB: begin rbuf <= st_rdata; st <= S_SYNC; end
        S_SYNC: st <= is_wr ? S_TBK : S_DLO;
        S_DLO:  st <= S_DHI;
        S_DHI:  st <= S_TBK;
        S_TBK:  st <= S_IDLE;
        S_ABORT: if (lad_in == 4'hF) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lad_oe   = (st == S_SYNC) || (st == S_DLO) || (st == S_DHI) || (st == S_TBK);
  assign lad_out  = (st == S_SYNC) ? 4'h0 :
                    (st == S_DLO)  ? rbuf[3:0] :
                    (st == S_DHI)  ? rbuf[7:4] : 4'hF;
  assign st_rd    = (st == S_TARA) && !is_wr;
  assign st_wr    = (st == S_TARA) && is_wr;
  assign st_addr  = addr[DEC_W-1:0];
  assign st_core  = addr[CORE_BIT];
  assign st_wdata = wbuf;
  assign busy     = (st != S_IDLE);

  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> !st_wr);
  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> !st_rd);
  a_r5_sync_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && frame_n) ##1 frame_n |=> (lad_oe && lad_out == 4'h0));
  a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && !frame_n) |=> !lad_oe);
  a_r9_first_drive_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h0);
  a_r9_float_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !lad_oe |-> lad_out == 4'hF);
endmodule

// File: tb/fwh_target_test.sv
module fwh_target_test;
  localparam logic [3:0] STRAP = 4'h5;

  logic clk = 0, rst_n = 0, frame_n = 1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic lad_oe, st_core, st_rd, st_wr, busy;
  logic [19:0] st_addr;
  logic [7:0] st_wdata, st_rdata;
  int n_chk = 0, n_fail = 0;
  logic o_oe, o_rd, o_wr, o_busy, o_core;
  logic [3:0] o_out;
  logic [19:0] o_addr;
  logic [7:0] o_wd;

  always #5 clk = ~clk;

  fwh_target uut (.clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(STRAP), .st_addr(st_addr),
    .st_core(st_core), .st_wdata(st_wdata), .st_rdata(st_rdata), .st_rd(st_rd),
    .st_wr(st_wr), .busy(busy));

  function automatic logic [7:0] model(input logic core, input logic [7:0] lo);
    return core ? (lo ^ 8'h5A) : {lo[3:0], lo[7:4]};
  endfunction
  assign st_rdata = model(st_core, st_addr[7:0]);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample();
    o_oe = lad_oe; o_out = lad_out; o_rd = st_rd; o_wr = st_wr; o_busy = busy;
    o_addr = st_addr; o_core = st_core; o_wd = st_wdata;
  endtask

  task automatic step(input logic f, input logic [3:0] n);
    @(posedge clk); #1;
    frame_n = f; lad_in = n;
    #1 sample();
  endtask

  task automatic bus_cycle(input logic [3:0] st, input int pre, input logic [3:0] idn,
                           input logic [27:0] a, input logic [3:0] sz, input logic [7:0] wd);
    bit wr = (st == 4'hE);
    bit idok = ((st == 4'hD) || (st == 4'hE)) && (idn == STRAP);
    bit ok = idok && (sz == 4'h0);
    logic [7:0] rb = model(a[22], a[7:0]);
    for (int i = 0; i < pre; i++) step(0, 4'hE);
    step(0, st);
    if (pre == 0) chk(o_busy == 0, "R10 idle busy", o_busy, 0);
    step(1, idn);
    for (int i = 0; i < 7; i++) begin
      step(1, a[27-4*i -: 4]);
      if (i == 3) chk(o_busy == idok, "R2/R10 busy after select", o_busy, idok);
    end
    step(1, sz);
    for (int c = 10; c <= 16; c++) begin
      logic [3:0] n = 4'hF;
      bit eoe, erd, ewr;
      logic [3:0] eout;
      if (wr && c == 10) n = wd[3:0];
      if (wr && c == 11) n = wd[7:4];
      step(1, n);
      eoe = ok && (wr ? (c == 14 || c == 15) : (c >= 12 && c <= 15));
      erd = ok && !wr && c == 10;
      ewr = ok && wr && c == 12;
      eout = 4'hF;
      if (eoe && !wr) eout = (c == 12) ? 4'h0 : (c == 13) ? rb[3:0] : (c == 14) ? rb[7:4] : 4'hF;
      if (eoe && wr) eout = (c == 14) ? 4'h0 : 4'hF;
      chk(o_oe == eoe, "R9 output enable", o_oe, eoe);
      chk(o_out == eout, wr ? "R6 write nibble" : "R5 read nibble", o_out, eout);
      chk(o_rd == erd, "R5 read strobe", o_rd, erd);
      chk(o_wr == ewr, "R6 write strobe", o_wr, ewr);
      if (erd || ewr) begin
        chk(o_addr == a[19:0], "R3 address", o_addr, a[19:0]);
        chk(o_core == a[22], "R3 region", o_core, a[22]);
        if (ewr) chk(o_wd == wd, "R6 write byte", o_wd, wd);
      end
    end
    chk(o_busy == 0, "R10 back to idle", o_busy, 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1 sample();
    chk(o_oe == 0, "R8 reset no drive", o_oe, 0);
    chk(o_busy == 0, "R8 reset idle", o_busy, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    bus_cycle(4'hD, 0, STRAP, 28'h0412345, 4'h0, 8'h00);
    bus_cycle(4'hE, 0, STRAP, 28'hFFBC0A7, 4'h0, 8'hA5);
    bus_cycle(4'hD, 2, STRAP, 28'h0400FF0, 4'h0, 8'h00);  // R1 last start wins
    bus_cycle(4'hE, 1, STRAP, 28'h00000FF, 4'h0, 8'h3C);
    bus_cycle(4'h2, 0, STRAP, 28'h0412345, 4'h0, 8'h00);  // R1 bad start
    bus_cycle(4'hD, 0, 4'h6, 28'h0412345, 4'h0, 8'h00);   // R2 foreign select
    bus_cycle(4'hE, 0, STRAP, 28'h0412345, 4'h1, 8'h11);  // R4 bad size
    bus_cycle(4'hD, 0, STRAP, 28'hFFFFFFF, 4'h0, 8'h00);
    // R7 abort during read data
    step(0, 4'hD); step(1, STRAP);
    for (int i = 0; i < 7; i++) step(1, 4'h4);
    step(1, 4'h0);
    for (int c = 10; c < 13; c++) step(1, 4'hF);
    chk(o_oe == 1, "R7 driving before abort", o_oe, 1);
    step(0, 4'hF);
    step(1, 4'h5);
    chk(o_oe == 0, "R7 drive stops", o_oe, 0);
    step(1, 4'h5);
    chk(o_busy == 1, "R7 waits for ones", o_busy, 1);
    step(1, 4'hF);
    step(1, 4'hF);
    chk(o_busy == 0, "R7 ready after ones", o_busy, 0);
    bus_cycle(4'hE, 0, STRAP, 28'h0401234, 4'h0, 8'h77);
    // R8 reset during sync
    step(0, 4'hD); step(1, STRAP);
    for (int i = 0; i < 7; i++) step(1, 4'h2);
    step(1, 4'h0);
    for (int c = 10; c < 13; c++) step(1, 4'hF);
    chk(o_oe == 1, "R8 driving before reset", o_oe, 1);
    rst_n = 0; #1 sample();
    chk(o_oe == 0, "R8 reset releases bus", o_oe, 0);
    chk(o_busy == 0, "R8 reset deselects", o_busy, 0);
    @(posedge clk); #1 rst_n = 1;
    bus_cycle(4'hD, 0, STRAP, 28'h0000010, 4'h0, 8'h00);
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r = $urandom;
      logic [3:0] st = (r[2:0] == 0) ? 4'h2 : (r[3] ? 4'hE : 4'hD);
      logic [3:0] idn = (r[7:4] % 5 == 0) ? (STRAP ^ {1'b0, r[10:8] | 3'b1}) : STRAP;
      logic [3:0] sz = (r[15:12] % 7 == 0) ? 4'h1 + {1'b0, r[18:16]} : 4'h0;
      bus_cycle(st, int'(r[20]), idn, 28'($urandom), sz, 8'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule